// File: doc/BRIEF.md
# Rate-Monotonic Register Bank Mapper

This unit assigns processor register banks to a set of periodic tasks so that the most frequently run tasks switch context without touching memory. Software writes one period per task slot, then pulses a start strobe with the number of active tasks. The unit ranks the tasks by period: the shortest period gets rank 0, the highest priority. It then hands out banks. The highest-priority tasks each receive a private bank. Every remaining task shares one common bank. The top bank is held back for interrupt handlers and is never given to a task.

Once the table is valid, a per-task readout returns each task's rank, bank and ownership. A combinational query port takes an outgoing and an incoming task. It reports whether the incoming task owns its bank, and whether the switch needs a save and restore because both tasks sit on the common bank. Register copying itself is done elsewhere.

Top module: `rm_bank_mapper`

## Requirements
- R1: Each active task (slot index below the latched count c) gets a unique rank 0..c-1, and a shorter period gives a smaller rank. Periods 1, 3, 5, 14, 57 get ranks 0, 1, 2, 3, 4 respectively.
- R2: Tasks with equal periods are ranked by slot index, with the lower index getting the smaller rank.
- R3: Banks are numbered 0..N_BANKS-1. Bank N_BANKS-1 is reserved for interrupts and is never reported for any task.
- R4: A task with rank r < N_BANKS-2 is given bank r, and its own flag is 1.
- R5: When c > N_BANKS-1, every task with rank >= N_BANKS-2 is given bank N_BANKS-2 with own flag 0. When c <= N_BANKS-1, every task is given bank equal to its rank with own flag 1.
- R6: q_in_own_o equals the own flag of the incoming task. q_save_o is 1 only when done_o is 1, both tasks are active and distinct, and neither task owns its bank.
- R7: A query whose outgoing and incoming indices are equal never reports a save.
- R8: done_o rises on the c-th clock edge after the edge that accepts start_i, or on that same edge when c is 0. It then stays high until the next accepted start or load.
- R9: A load accepted while idle clears done_o on the same edge. A load presented while a mapping is in progress writes nothing.
- R10: After reset, and for any slot index >= c, the readout gives rd_valid_o=0, rd_prio_o=0, rd_bank_o=0 and rd_own_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write a task period |
| load_idx_i | input | $clog2(N_TASKS) | Slot written by load |
| load_period_i | input | PERIOD_W | Period value for the slot |
| start_i | input | 1 | Begin mapping |
| task_cnt_i | input | $clog2(N_TASKS+1) | Active task count, sampled at start and clamped to N_TASKS |
| done_o | output | 1 | Assignment table valid |
| rd_idx_i | input | $clog2(N_TASKS) | Readout slot |
| rd_valid_o | output | 1 | Slot is active and the table is valid |
| rd_prio_o | output | $clog2(N_TASKS) | Rank of the slot |
| rd_bank_o | output | $clog2(N_BANKS) | Bank of the slot |
| rd_own_o | output | 1 | Slot has a bank to itself |
| q_out_idx_i | input | $clog2(N_TASKS) | Outgoing task of a switch |
| q_in_idx_i | input | $clog2(N_TASKS) | Incoming task of a switch |
| q_in_own_o | output | 1 | Incoming task owns its bank |
| q_save_o | output | 1 | Switch needs save and restore on the shared bank |

## Verification
The bench builds the block with N_TASKS=8 and N_BANKS=4. With these values only two private banks exist, so five loaded tasks already overflow onto the common bank. A three-task load fills exactly the three assignable banks, which exercises the boundary where the last bank stops being shared. Eight slots leave inactive entries to read back, and they allow a zero-count run and a tie among three equal periods.

// File: rtl/rm_map_pkg.sv
package rm_map_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} map_state_e;
endpackage

// File: rtl/rm_period_regs.sv
module rm_period_regs #(
  parameter int N_TASKS  = 8,
  parameter int PERIOD_W = 16,
  localparam int IDXW    = $clog2(N_TASKS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IDXW-1:0]                   idx_i,
  input  logic [PERIOD_W-1:0]               period_i,
  output logic [N_TASKS-1:0][PERIOD_W-1:0]  period_o
);
  for (genvar g = 0; g < N_TASKS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            period_o[g] <= '0;
      else if (we_i && idx_i == IDXW'(g))     period_o[g] <= period_i;
    end
  end
endmodule

// File: rtl/rm_rank_engine.sv
module rm_rank_engine
  import rm_map_pkg::*;
#(
  parameter int N_TASKS  = 8,
  parameter int PERIOD_W = 16,
  localparam int IDXW    = $clog2(N_TASKS),
  localparam int CNTW    = $clog2(N_TASKS + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [CNTW-1:0]                   cnt_i,
  input  logic [N_TASKS-1:0][PERIOD_W-1:0]  period_i,
  output logic                              busy_o,
  output logic                              accept_o,
  output logic [CNTW-1:0]                   cnt_o,
  output logic                              wr_en_o,
  output logic [IDXW-1:0]                   wr_idx_o,
  output logic [IDXW-1:0]                   wr_rank_o,
  output logic                              fin_o
);
  map_state_e       state_q;
  logic [IDXW-1:0]  cur_q;
  logic [CNTW-1:0]  cnt_q;
  logic [CNTW-1:0]  cnt_clamp;
  logic [N_TASKS-1:0] ahead;
  logic             last;

  assign cnt_clamp = (int'(cnt_i) > N_TASKS) ? CNTW'(N_TASKS) : cnt_i;
  assign busy_o    = (state_q == ST_RUN);
  assign accept_o  = start_i && !busy_o;
  assign cnt_o     = cnt_q;

  // a slot ranks ahead of cur when its period is shorter, or equal with lower index
  for (genvar j = 0; j < N_TASKS; j++) begin : g_cmp
    always_comb begin
      ahead[j] = 1'b0;
      if (CNTW'(j) < cnt_q && IDXW'(j) != cur_q) begin
        if (period_i[j] < period_i[cur_q])
          ahead[j] = 1'b1;
        else if (period_i[j] == period_i[cur_q] && IDXW'(j) < cur_q)
          ahead[j] = 1'b1;
      end
    end
  end

  assign last      = (CNTW'(cur_q) == cnt_q - CNTW'(1));
  assign wr_en_o   = busy_o;
  assign wr_idx_o  = cur_q;
  assign wr_rank_o = IDXW'($countones(ahead));
  assign fin_o     = (busy_o && last) || (accept_o && cnt_clamp == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q <= cnt_clamp;
            cur_q <= '0;
            if (cnt_clamp != '0) state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last) state_q <= ST_IDLE;
          else      cur_q   <= cur_q + IDXW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_bank_table.sv
module rm_bank_table #(
  parameter int N_TASKS = 8,
  parameter int N_BANKS = 4,
  localparam int IDXW   = $clog2(N_TASKS),
  localparam int CNTW   = $clog2(N_TASKS + 1),
  localparam int BW     = $clog2(N_BANKS),
  localparam int SHARED = N_BANKS - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              load_clr_i,
  input  logic [CNTW-1:0]   cnt_i,
  input  logic              wr_en_i,
  input  logic [IDXW-1:0]   wr_idx_i,
  input  logic [IDXW-1:0]   wr_rank_i,
  input  logic              fin_i,
  output logic              done_o,
  input  logic [IDXW-1:0]   rd_idx_i,
  output logic              rd_valid_o,
  output logic [IDXW-1:0]   rd_prio_o,
  output logic [BW-1:0]     rd_bank_o,
  output logic              rd_own_o,
  input  logic [IDXW-1:0]   q_out_idx_i,
  input  logic [IDXW-1:0]   q_in_idx_i,
  output logic              q_in_own_o,
  output logic              q_save_o
);
  logic [N_TASKS-1:0][IDXW-1:0] rank_q;
  logic [N_TASKS-1:0]           act_q;
  logic                         done_q;
  logic                         overflow;

  assign overflow = (int'(cnt_i) > N_BANKS - 1);
  assign done_o   = done_q;

  function automatic logic slot_live(logic [IDXW-1:0] i, logic [N_TASKS-1:0] act);
    return (int'(i) < N_TASKS) && act[i];
  endfunction

  function automatic logic own_of(logic [IDXW-1:0] r, logic live, logic ovf);
    return live && ((int'(r) < SHARED) || !ovf);
  endfunction

  function automatic logic [BW-1:0] bank_of(logic [IDXW-1:0] r);
    return (int'(r) < SHARED) ? BW'(r) : BW'(SHARED);
  endfunction

  for (genvar g = 0; g < N_TASKS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank_q[g] <= '0;
        act_q[g]  <= 1'b0;
      end else if (accept_i) begin
        act_q[g]  <= 1'b0;
        rank_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IDXW'(g)) begin
        act_q[g]  <= 1'b1;
        rank_q[g] <= wr_rank_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      done_q <= 1'b0;
    else if (fin_i)                   done_q <= 1'b1;
    else if (accept_i || load_clr_i)  done_q <= 1'b0;
  end

  logic rd_live, in_live, out_live, out_own;
  logic [IDXW-1:0] rd_r, in_r, out_r;

  always_comb begin
    rd_live  = done_q && slot_live(rd_idx_i, act_q);
    in_live  = done_q && slot_live(q_in_idx_i, act_q);
    out_live = done_q && slot_live(q_out_idx_i, act_q);
    rd_r     = rd_live  ? rank_q[rd_idx_i]    : '0;
    in_r     = in_live  ? rank_q[q_in_idx_i]  : '0;
    out_r    = out_live ? rank_q[q_out_idx_i] : '0;

    rd_valid_o = rd_live;
    rd_prio_o  = rd_r;
    rd_bank_o  = rd_live ? bank_of(rd_r) : '0;
    rd_own_o   = own_of(rd_r, rd_live, overflow);

    q_in_own_o = own_of(in_r, in_live, overflow);
    out_own    = own_of(out_r, out_live, overflow);
    q_save_o   = in_live && out_live && (q_in_idx_i != q_out_idx_i)
                 && !q_in_own_o && !out_own;
  end
endmodule

// File: rtl/rm_bank_mapper.sv
module rm_bank_mapper #(
  parameter int N_TASKS  = 8,
  parameter int N_BANKS  = 4,
  parameter int PERIOD_W = 16,
  localparam int IDXW    = $clog2(N_TASKS),
  localparam int CNTW    = $clog2(N_TASKS + 1),
  localparam int BW      = $clog2(N_BANKS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [IDXW-1:0]     load_idx_i,
  input  logic [PERIOD_W-1:0] load_period_i,
  input  logic                start_i,
  input  logic [CNTW-1:0]     task_cnt_i,
  output logic                done_o,
  input  logic [IDXW-1:0]     rd_idx_i,
  output logic                rd_valid_o,
  output logic [IDXW-1:0]     rd_prio_o,
  output logic [BW-1:0]       rd_bank_o,
  output logic                rd_own_o,
  input  logic [IDXW-1:0]     q_out_idx_i,
  input  logic [IDXW-1:0]     q_in_idx_i,
  output logic                q_in_own_o,
  output logic                q_save_o
);
  logic [N_TASKS-1:0][PERIOD_W-1:0] periods;
  logic              busy, accept, wr_en, fin, load_ok;
  logic [CNTW-1:0]   cnt;
  logic [IDXW-1:0]   wr_idx, wr_rank;

  assign load_ok = load_i && !busy;

  rm_period_regs #(.N_TASKS(N_TASKS), .PERIOD_W(PERIOD_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(load_ok), .idx_i(load_idx_i), .period_i(load_period_i),
    .period_o(periods)
  );

  rm_rank_engine #(.N_TASKS(N_TASKS), .PERIOD_W(PERIOD_W)) u_rank (
    .clk_i, .rst_ni,
    .start_i, .cnt_i(task_cnt_i), .period_i(periods),
    .busy_o(busy), .accept_o(accept), .cnt_o(cnt),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_rank_o(wr_rank), .fin_o(fin)
  );

  rm_bank_table #(.N_TASKS(N_TASKS), .N_BANKS(N_BANKS)) u_table (
    .clk_i, .rst_ni,
    .accept_i(accept), .load_clr_i(load_ok), .cnt_i(cnt),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_rank_i(wr_rank), .fin_i(fin),
    .done_o,
    .rd_idx_i, .rd_valid_o, .rd_prio_o, .rd_bank_o, .rd_own_o,
    .q_out_idx_i, .q_in_idx_i, .q_in_own_o, .q_save_o
  );
endmodule

// File: rtl/rm_bank_mapper_chk.sv
module rm_bank_mapper_chk #(
  parameter int N_TASKS = 8,
  parameter int N_BANKS = 4,
  localparam int IDXW   = $clog2(N_TASKS),
  localparam int BW     = $clog2(N_BANKS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy,
  input logic            load_i,
  input logic            start_i,
  input logic            done_o,
  input logic            rd_valid_o,
  input logic [BW-1:0]   rd_bank_o,
  input logic            rd_own_o,
  input logic [IDXW-1:0] q_out_idx_i,
  input logic [IDXW-1:0] q_in_idx_i,
  input logic            q_in_own_o,
  input logic            q_save_o
);
  // R3
  reserved_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (int'(rd_bank_o) != N_BANKS - 1));

  // R4
  private_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && int'(rd_bank_o) < N_BANKS - 2) |-> rd_own_o);

  // R6
  save_not_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_save_o |-> (done_o && !q_in_own_o));

  // R7
  same_task_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_out_idx_i == q_in_idx_i) |-> !q_save_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);

  // R9
  load_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy && !start_i) |=> !done_o);

  // R10
  invalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_bank_o == '0 && !rd_own_o));
endmodule

bind rm_bank_mapper rm_bank_mapper_chk #(.N_TASKS(N_TASKS), .N_BANKS(N_BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .load_i(load_i), .start_i(start_i),
  .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_bank_o(rd_bank_o), .rd_own_o(rd_own_o),
  .q_out_idx_i(q_out_idx_i), .q_in_idx_i(q_in_idx_i),
  .q_in_own_o(q_in_own_o), .q_save_o(q_save_o)
);

// File: tb/rm_bank_mapper_tb.sv
module rm_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int NB = 4;
  localparam int PW = 16;
  localparam int IDXW = $clog2(NT);
  localparam int CNTW = $clog2(NT + 1);
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [IDXW-1:0] load_idx = '0;
  logic [PW-1:0] load_per = '0;
  logic start = 1'b0;
  logic [CNTW-1:0] cnt = '0;
  logic done;
  logic [IDXW-1:0] rd_idx = '0;
  logic rd_valid, rd_own;
  logic [IDXW-1:0] rd_prio;
  logic [BW-1:0] rd_bank;
  logic [IDXW-1:0] q_out = '0, q_in = '0;
  logic q_own, q_save;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rm_bank_mapper #(.N_TASKS(NT), .N_BANKS(NB), .PERIOD_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_i(load), .load_idx_i(load_idx), .load_period_i(load_per),
    .start_i(start), .task_cnt_i(cnt), .done_o(done),
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_prio_o(rd_prio),
    .rd_bank_o(rd_bank), .rd_own_o(rd_own),
    .q_out_idx_i(q_out), .q_in_idx_i(q_in), .q_in_own_o(q_own), .q_save_o(q_save)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_slot(input int idx, input int per);
    @(negedge clk);
    load = 1'b1; load_idx = IDXW'(idx); load_per = PW'(per);
    @(negedge clk);
    load = 1'b0;
  endtask

  // start a mapping and check done latency (R8)
  task automatic run_map(input int c);
    int edges;
    int exp_edges;
    exp_edges = (c == 0) ? 1 : c + 1;
    @(negedge clk);
    start = 1'b1; cnt = CNTW'(c);
    edges = 0;
    @(posedge clk); edges++;
    #1 start = 1'b0;
    while (!done && edges < 64) begin
      @(posedge clk); edges++;
      #1;
    end
    chk("R8", "done latency in edges", edges, exp_edges);
  endtask

  task automatic check_slot(input string req, input int idx, input int v,
                            input int p, input int b, input int o);
    @(negedge clk);
    rd_idx = IDXW'(idx);
    #1;
    chk(req, $sformatf("slot %0d valid", idx), int'(rd_valid), v);
    chk(req, $sformatf("slot %0d prio", idx), int'(rd_prio), p);
    chk(req, $sformatf("slot %0d bank", idx), int'(rd_bank), b);
    chk(req, $sformatf("slot %0d own", idx), int'(rd_own), o);
  endtask

  task automatic check_query(input string req, input int o_idx, input int i_idx,
                             input int own, input int save);
    @(negedge clk);
    q_out = IDXW'(o_idx); q_in = IDXW'(i_idx);
    #1;
    chk(req, $sformatf("query %0d->%0d in_own", o_idx, i_idx), int'(q_own), own);
    chk(req, $sformatf("query %0d->%0d save", o_idx, i_idx), int'(q_save), save);
  endtask

  task automatic t_reset;
    chk("R10", "done after reset", int'(done), 0);
    check_slot("R10", 0, 0, 0, 0, 0);
  endtask

  task automatic load_example;
    load_slot(0, 14); load_slot(1, 1); load_slot(2, 57);
    load_slot(3, 5);  load_slot(4, 3);
  endtask

  // five tasks on four banks: two private, one shared, one reserved
  task automatic t_overflow;
    load_example();
    run_map(5);
    check_slot("R1", 1, 1, 0, 0, 1);
    check_slot("R4", 4, 1, 1, 1, 1);
    check_slot("R5", 3, 1, 2, 2, 0);
    check_slot("R5", 0, 1, 3, 2, 0);
    check_slot("R3", 2, 1, 4, 2, 0);
    check_slot("R10", 5, 0, 0, 0, 0);
    check_query("R6", 3, 0, 0, 1);
    check_query("R6", 1, 3, 0, 0);
    check_query("R6", 2, 1, 1, 0);
    check_query("R7", 3, 3, 0, 0);
  endtask

  task automatic t_ties;
    load_slot(0, 7); load_slot(1, 7); load_slot(2, 2); load_slot(3, 7);
    run_map(4);
    check_slot("R2", 2, 1, 0, 0, 1);
    check_slot("R2", 0, 1, 1, 1, 1);
    check_slot("R2", 1, 1, 2, 2, 0);
    check_slot("R2", 3, 1, 3, 2, 0);
    check_query("R6", 1, 3, 0, 1);
  endtask

  task automatic t_fit;
    load_slot(0, 9); load_slot(1, 4); load_slot(2, 6);
    run_map(3);
    check_slot("R5", 0, 1, 2, 2, 1);
    check_slot("R5", 1, 1, 0, 0, 1);
    check_slot("R5", 2, 1, 1, 1, 1);
    check_slot("R10", 3, 0, 0, 0, 0);
    check_query("R6", 1, 0, 1, 0);
  endtask

  task automatic t_zero;
    run_map(0);
    check_slot("R10", 0, 0, 0, 0, 0);
  endtask

  task automatic t_load_busy;
    load_example();
    @(negedge clk);
    start = 1'b1; cnt = CNTW'(5);
    @(negedge clk);
    start = 1'b0;
    load = 1'b1; load_idx = IDXW'(2); load_per = PW'(0);
    @(negedge clk);
    load = 1'b0;
    while (!done) @(negedge clk);
    check_slot("R9", 2, 1, 4, 2, 0);
    run_map(5);
    check_slot("R9", 2, 1, 4, 2, 0);
    check_slot("R9", 1, 1, 0, 0, 1);
  endtask

  task automatic t_load_clears;
    chk("R8", "done held before load", int'(done), 1);
    load_slot(0, 14);
    #1;
    chk("R9", "done after idle load", int'(done), 0);
    check_slot("R9", 1, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_overflow();
    t_ties();
    t_fit();
    t_zero();
    t_load_busy();
    t_load_clears();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule